// File: doc/BRIEF.md
# Asynchronous SRAM Write-Timing Monitor

This block watches the pins of an asynchronous 16-bit static memory port. It samples them with a fast reference clock and rebuilds every write cycle from the four controls that gate it. Those controls are a high-active select, a low-active enable, a low-active write strobe, and a set of low-active byte-lane enables.

A write window is open on any sample where all four are active. It opens on the sample where the last of them becomes active and closes on the sample where the first of them drops. The monitor records which control opened the window and which one closed it. It then measures the window width, the address and data setup, the address hold, the address cycle time and bus contention against thresholds given in nanoseconds. Each threshold is converted to sample ticks by rounding up.

Each rule has a sticky error bit. Every window close gives a one-cycle pulse, and a counter tracks the windows that closed without a timing fault. The monitor is placed beside a memory controller or at a board-level bus in a system model. It does not model the storage array.

Top module: `sram_wr_mon`

## Requirements
- R1: A window is open on a sample where `cs_i`=1, `ce_ni`=0, `we_ni`=0 and at least one `be_ni` bit is 0. On the first sample after a window where this no longer holds, `wr_done_o` pulses for one cycle.
- R2: The opener is the control that became active on the opening sample. The closer is the control that is inactive on the closing sample. Ties are resolved in the order enable, byte enables, write strobe, select. The codes are 0=enable, 1=write strobe, 2=byte enables, 3=select. On a width, address-setup or data-setup fault, `viol_open_o` and `viol_close_o` take these codes.
- R3: The window must last at least ceil(WIN_NS/SAMPLE_NS) samples, which is 15 at default. The minimum drops to ceil(WE_WIN_NS/SAMPLE_NS) samples, 13 at default, only when the write strobe both opened and closed the window. A shorter window sets err bit 0.
- R4: At the last in-window sample, the address must have held its value for at least ceil(ADDR_SU_NS/SAMPLE_NS) consecutive samples, 15 at default. Otherwise err bit 1 is set.
- R5: An address change between two consecutive in-window samples sets err bit 2.
- R6: For each enabled lane, the data must have held for at least ceil(DATA_SU_NS/SAMPLE_NS) samples, 8 at default, at the last in-window sample. Otherwise err bit 3 is set. A lane counts as enabled when its `be_ni` bit was 0 on that sample. Lane i is `data_i[8i+7:8i]`. Lanes that are not enabled are ignored.
- R7: When the address changes after holding its value for fewer than ceil(CYCLE_NS/SAMPLE_NS) samples, 18 at default, err bit 4 is set.
- R8: The memory is driving the bus while `cs_i`=1, `ce_ni`=0, `oe_ni`=0 and any `be_ni` bit is 0. Host drive (`host_drv_i`=1) during that time sets err bit 5. The exception is host drive once the write strobe has been low for more than ceil(WE_HIZ_NS/SAMPLE_NS) samples, 5 at default.
- R9: Error bits stay set until `clr_i` is sampled high. `wr_cnt_o` increments only on a close whose window raised no width, setup or hold fault.
- R10: After reset, `err_o`=0, `wr_cnt_o`=0, `wr_done_o`=0 and both source outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | sample clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| clr_i | input | 1 | synchronous clear of sticky errors |
| addr_i | input | AW | sampled address |
| data_i | input | DW | sampled data bus |
| cs_i | input | 1 | select, active high |
| ce_ni | input | 1 | enable, active low |
| oe_ni | input | 1 | output enable, active low |
| we_ni | input | 1 | write strobe, active low |
| be_ni | input | DW/8 | byte-lane enables, active low |
| host_drv_i | input | 1 | host is driving the data bus |
| err_o | output | 6 | sticky error bits (R3..R8) |
| viol_open_o | output | 2 | opener of the last faulted window |
| viol_close_o | output | 2 | closer of the last faulted window |
| wr_done_o | output | 1 | one-cycle pulse per window close |
| wr_cnt_o | output | CNT_W | count of legal writes |

## Verification
Windows are opened and closed by each control in turn, including mixed opener and closer pairs and a simultaneous fall of the enable and the write strobe. This shows whether the 50 ns limit is applied only to strobe-only windows and whether tie priority is honoured. Each timing rule is driven one sample below its threshold and exactly at it, so a rounding or off-by-one error in the tick conversion shows up. A late change on a disabled lane separates true lane masking from a check over the whole bus. Contention is probed on the fifth and the sixth low-strobe sample to locate the high-impedance grace boundary.

// File: rtl/sram_wr_mon_pkg.sv
`timescale 1ns/1ps
package sram_wr_mon_pkg;
  typedef enum logic [1:0] {
    SRC_CE = 2'd0,
    SRC_WE = 2'd1,
    SRC_BE = 2'd2,
    SRC_CS = 2'd3
  } win_src_e;

  localparam int unsigned NUM_ERR  = 6;
  localparam int unsigned E_WIDTH  = 0;
  localparam int unsigned E_ASETUP = 1;
  localparam int unsigned E_AHOLD  = 2;
  localparam int unsigned E_DSETUP = 3;
  localparam int unsigned E_CYCLE  = 4;
  localparam int unsigned E_CONT   = 5;

  function automatic int unsigned ns2tick(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction
endpackage

// File: rtl/sram_wr_mon_run.sv
`timescale 1ns/1ps
// Saturating count of consecutive samples with an unchanged value.
module sram_wr_mon_run #(
  parameter  int unsigned W    = 8,
  parameter  int unsigned MAXC = 16,
  localparam int unsigned CW   = $clog2(MAXC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  val_i,
  output logic          chg_o,
  output logic [CW-1:0] run_o
);
  logic [W-1:0]  prev_q;
  logic          prime_q;
  logic [CW-1:0] run_q, run_d;

  assign chg_o = prime_q && (val_i != prev_q);
  assign run_o = run_q;

  always_comb begin
    if (chg_o)                   run_d = CW'(1);
    else if (run_q == CW'(MAXC)) run_d = run_q;
    else                         run_d = run_q + CW'(1);
  end

  // reset treats the value as long stable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      prime_q <= 1'b0;
      run_q   <= CW'(MAXC);
    end else begin
      prev_q  <= val_i;
      prime_q <= 1'b1;
      run_q   <= run_d;
    end
  end
endmodule

// File: rtl/sram_wr_mon_win.sv
`timescale 1ns/1ps
module sram_wr_mon_win
  import sram_wr_mon_pkg::*;
#(
  parameter  int unsigned LANES = 2,
  parameter  int unsigned LMAX  = 16,
  localparam int unsigned LW    = $clog2(LMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] be_ni,
  output logic             in_o,
  output logic             open_o,
  output logic             close_o,
  output win_src_e         open_src_o,
  output win_src_e         close_src_o,
  output logic [LW-1:0]    len_o
);
  logic ce_act, we_act, be_act;
  logic cs_q, ce_q, we_q, be_q, win_q;
  win_src_e open_src_d, open_src_q;
  logic [LW-1:0] len_q;

  assign ce_act  = ~ce_ni;
  assign we_act  = ~we_ni;
  assign be_act  = ~&be_ni;
  assign in_o    = cs_i & ce_act & we_act & be_act;
  assign open_o  = in_o & ~win_q;
  assign close_o = ~in_o & win_q;

  always_comb begin
    if (~ce_q)      open_src_d = SRC_CE;
    else if (~be_q) open_src_d = SRC_BE;
    else if (~we_q) open_src_d = SRC_WE;
    else if (~cs_q) open_src_d = SRC_CS;
    else            open_src_d = SRC_CE;
  end

  always_comb begin
    if (ce_ni)       close_src_o = SRC_CE;
    else if (~be_act) close_src_o = SRC_BE;
    else if (we_ni)  close_src_o = SRC_WE;
    else             close_src_o = SRC_CS;
  end

  assign open_src_o = open_src_q;
  assign len_o      = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b0;
      ce_q       <= 1'b0;
      we_q       <= 1'b0;
      be_q       <= 1'b0;
      win_q      <= 1'b0;
      open_src_q <= SRC_CE;
      len_q      <= '0;
    end else begin
      cs_q  <= cs_i;
      ce_q  <= ce_act;
      we_q  <= we_act;
      be_q  <= be_act;
      win_q <= in_o;
      if (open_o) begin
        open_src_q <= open_src_d;
        len_q      <= LW'(1);
      end else if (in_o && len_q != LW'(LMAX)) begin
        len_q <= len_q + LW'(1);
      end
    end
  end

  a_r1_close_has_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |-> len_q != '0);
endmodule

// File: rtl/sram_wr_mon.sv
`timescale 1ns/1ps
module sram_wr_mon
  import sram_wr_mon_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned DW         = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SAMPLE_NS  = 4,
  parameter int unsigned WIN_NS     = 60,
  parameter int unsigned WE_WIN_NS  = 50,
  parameter int unsigned ADDR_SU_NS = 60,
  parameter int unsigned DATA_SU_NS = 30,
  parameter int unsigned CYCLE_NS   = 70,
  parameter int unsigned WE_HIZ_NS  = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  input  logic                cs_i,
  input  logic                ce_ni,
  input  logic                oe_ni,
  input  logic                we_ni,
  input  logic [DW/8-1:0]     be_ni,
  input  logic                host_drv_i,
  output logic [NUM_ERR-1:0]  err_o,
  output logic [1:0]          viol_open_o,
  output logic [1:0]          viol_close_o,
  output logic                wr_done_o,
  output logic [CNT_W-1:0]    wr_cnt_o
);
  localparam int unsigned LANES = DW / 8;
  localparam int unsigned T_WIN = ns2tick(WIN_NS, SAMPLE_NS);
  localparam int unsigned T_WEW = ns2tick(WE_WIN_NS, SAMPLE_NS);
  localparam int unsigned T_ASU = ns2tick(ADDR_SU_NS, SAMPLE_NS);
  localparam int unsigned T_DSU = ns2tick(DATA_SU_NS, SAMPLE_NS);
  localparam int unsigned T_CYC = ns2tick(CYCLE_NS, SAMPLE_NS);
  localparam int unsigned T_WLZ = ns2tick(WE_HIZ_NS, SAMPLE_NS);
  localparam int unsigned A_MAX = (T_ASU > T_CYC) ? T_ASU : T_CYC;
  localparam int unsigned L_MAX = (T_WIN > T_WEW) ? T_WIN : T_WEW;
  localparam int unsigned Z_MAX = T_WLZ + 1;
  localparam int unsigned ACW   = $clog2(A_MAX + 1);
  localparam int unsigned DCW   = $clog2(T_DSU + 1);
  localparam int unsigned LW    = $clog2(L_MAX + 1);
  localparam int unsigned ZW    = $clog2(Z_MAX + 1);

  // window tracking
  logic          in_win, win_open, win_close;
  win_src_e      src_open, src_close;
  logic [LW-1:0] win_len;

  sram_wr_mon_win #(.LANES(LANES), .LMAX(L_MAX)) u_win (
    .clk_i, .rst_ni, .cs_i, .ce_ni, .we_ni, .be_ni,
    .in_o(in_win), .open_o(win_open), .close_o(win_close),
    .open_src_o(src_open), .close_src_o(src_close), .len_o(win_len)
  );

  // address and data stability
  logic           a_chg;
  logic [ACW-1:0] a_run;
  sram_wr_mon_run #(.W(AW), .MAXC(A_MAX)) u_arun (
    .clk_i, .rst_ni, .val_i(addr_i), .chg_o(a_chg), .run_o(a_run)
  );

  logic [LANES-1:0] be_prev_q;
  logic [LANES-1:0] d_chg, lane_bad;
  logic [DCW-1:0]   d_run [LANES];

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    sram_wr_mon_run #(.W(8), .MAXC(T_DSU)) u_drun (
      .clk_i, .rst_ni, .val_i(data_i[gi*8 +: 8]), .chg_o(d_chg[gi]), .run_o(d_run[gi])
    );
    assign lane_bad[gi] = ~be_prev_q[gi] && (d_run[gi] < DCW'(T_DSU));

    a_r6_lane_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      d_chg[gi] |=> d_run[gi] == DCW'(1));
  end

  // write-strobe low time for the output turn-off grace
  logic [ZW-1:0] wl_q, wl_now;
  always_comb begin
    if (we_ni)                   wl_now = '0;
    else if (wl_q == ZW'(Z_MAX)) wl_now = wl_q;
    else                         wl_now = wl_q + ZW'(1);
  end

  logic mem_drv, cont_ev;
  assign mem_drv = cs_i & ~ce_ni & ~oe_ni & ~&be_ni;
  assign cont_ev = host_drv_i & mem_drv & (we_ni | (wl_now <= ZW'(T_WLZ)));

  // rule evaluation
  logic          we_only;
  logic [LW-1:0] min_len;
  logic          width_ev, asu_ev, dsu_ev, ahold_ev, cyc_ev, legal;
  logic          hold_seen_q;
  logic [NUM_ERR-1:0] ev, err_q;

  assign we_only  = (src_open == SRC_WE) && (src_close == SRC_WE);
  assign min_len  = we_only ? LW'(T_WEW) : LW'(T_WIN);
  assign width_ev = win_close && (win_len < min_len);
  assign asu_ev   = win_close && (a_run < ACW'(T_ASU));
  assign dsu_ev   = win_close && (|lane_bad);
  assign ahold_ev = in_win && !win_open && a_chg;
  assign cyc_ev   = a_chg && (a_run < ACW'(T_CYC));
  assign legal    = win_close && !width_ev && !asu_ev && !dsu_ev && !hold_seen_q;

  always_comb begin
    ev           = '0;
    ev[E_WIDTH]  = width_ev;
    ev[E_ASETUP] = asu_ev;
    ev[E_AHOLD]  = ahold_ev;
    ev[E_DSETUP] = dsu_ev;
    ev[E_CYCLE]  = cyc_ev;
    ev[E_CONT]   = cont_ev;
  end

  win_src_e         viol_open_q, viol_close_q;
  logic             wr_done_q;
  logic [CNT_W-1:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_prev_q    <= '1;
      wl_q         <= '0;
      hold_seen_q  <= 1'b0;
      err_q        <= '0;
      viol_open_q  <= SRC_CE;
      viol_close_q <= SRC_CE;
      wr_done_q    <= 1'b0;
      wr_cnt_q     <= '0;
    end else begin
      be_prev_q <= be_ni;
      wl_q      <= wl_now;
      if (win_open)      hold_seen_q <= 1'b0;
      else if (ahold_ev) hold_seen_q <= 1'b1;
      err_q <= (clr_i ? '0 : err_q) | ev;
      if (width_ev || asu_ev || dsu_ev) begin
        viol_open_q  <= src_open;
        viol_close_q <= src_close;
      end
      wr_done_q <= win_close;
      wr_cnt_q  <= wr_cnt_q + CNT_W'(legal);
    end
  end

  assign err_o        = err_q;
  assign viol_open_o  = viol_open_q;
  assign viol_close_o = viol_close_q;
  assign wr_done_o    = wr_done_q;
  assign wr_cnt_o     = wr_cnt_q;

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (err_q & $past(err_q)) == $past(err_q));

  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt_q != $past(wr_cnt_q)) |-> (wr_done_q && wr_cnt_q == $past(wr_cnt_q) + CNT_W'(1)));

  a_r5_hold_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q[E_AHOLD]) |-> $past(in_win));

  a_r3_short_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_close && win_len < LW'(T_WEW)) |=> err_q[E_WIDTH]);

  a_r7_addr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_chg |=> a_run == ACW'(1));
endmodule

// File: tb/sram_wr_mon_tb_top.sv
`timescale 1ns/1ps
module sram_wr_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic        cs = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, host = 1'b0;
  logic [1:0]  be_n = 2'b11;
  logic [5:0]  err;
  logic [1:0]  vo, vc;
  logic        done;
  logic [15:0] cnt;

  int n_chk = 0, n_bad = 0;
  int exp_cnt = 0;
  logic last_done;

  always #2 clk = ~clk;

  sram_wr_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .addr_i(addr), .data_i(data),
    .cs_i(cs), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .be_ni(be_n),
    .host_drv_i(host), .err_o(err), .viol_open_o(vo), .viol_close_o(vc),
    .wr_done_o(done), .wr_cnt_o(cnt)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    ce_n = 1'b1; we_n = 1'b1; be_n = 2'b11; oe_n = 1'b1; host = 1'b0;
  endtask

  task automatic clear_all();
    go_idle();
    step(20);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
  endtask

  // ob/cb: 0 enable, 1 strobe, 2 byte enables, 3 enable+strobe together
  task automatic wr(input int ob, input int cb, input logic [19:0] a, input logic [15:0] d,
                    input logic [1:0] be, input int pre, input int len, input int late,
                    input logic [1:0] lmask, input int post);
    addr = a;
    data = (late > 0) ? (d ^ {{8{lmask[1]}}, {8{lmask[0]}}}) : d;
    host = 1'b1;
    ce_n = (ob == 0 || ob == 3);
    we_n = (ob == 1 || ob == 3);
    be_n = (ob == 2) ? 2'b11 : be;
    step(pre);
    ce_n = 1'b0; we_n = 1'b0; be_n = be;
    if (late > 0) begin
      step(late);
      data = d;
      step(len - late);
    end else begin
      step(len);
    end
    case (cb)
      0: ce_n = 1'b1;
      1: we_n = 1'b1;
      2: be_n = 2'b11;
      default: begin ce_n = 1'b1; we_n = 1'b1; end
    endcase
    step(1);
    last_done = done;
    step(post);
    go_idle();
  endtask

  task automatic t_reset();
    check("R10 err", 32'(err), 0);
    check("R10 cnt", 32'(cnt), 0);
    check("R10 done", 32'(done), 0);
    check("R10 src", 32'({vo, vc}), 0);
  endtask

  task automatic t_basic();
    clear_all();
    wr(1, 1, 20'h00100, 16'hA55A, 2'b00, 2, 15, 0, 2'b00, 4);
    exp_cnt++;
    check("R1 done pulse", 32'(last_done), 1);
    check("R1 err", 32'(err), 0);
    check("R1 cnt", 32'(cnt), 32'(exp_cnt));
    step(1);
    check("R1 done one cycle", 32'(done), 0);
    wr(1, 1, 20'h00101, 16'h1234, 2'b00, 2, 13, 0, 2'b00, 4);
    exp_cnt++;
    check("R3 strobe-only 13 legal", 32'(err), 0);
    check("R3 cnt", 32'(cnt), 32'(exp_cnt));
  endtask

  task automatic t_width();
    clear_all();
    wr(1, 1, 20'h00200, 16'h0F0F, 2'b00, 4, 12, 0, 2'b00, 4);
    check("R3 strobe 12 short", 32'(err), 32'h01);
    check("R2 src strobe", 32'({vo, vc}), 32'b0101);
    check("R9 cnt unchanged", 32'(cnt), 32'(exp_cnt));
    clear_all();
    wr(0, 0, 20'h00201, 16'h0F0F, 2'b00, 2, 14, 0, 2'b00, 4);
    check("R3 enable 14 short", 32'(err), 32'h01);
    check("R2 src enable", 32'({vo, vc}), 32'b0000);
    clear_all();
    wr(0, 0, 20'h00202, 16'h0F0F, 2'b00, 2, 15, 0, 2'b00, 4);
    exp_cnt++;
    check("R3 enable 15 legal", 32'(err), 0);
    check("R3 cnt", 32'(cnt), 32'(exp_cnt));
  endtask

  task automatic t_src();
    clear_all();
    wr(2, 1, 20'h00300, 16'h7777, 2'b00, 2, 13, 0, 2'b00, 4);
    check("R3 mixed 13 short", 32'(err), 32'h01);
    check("R2 open be close strobe", 32'({vo, vc}), 32'b1001);
    clear_all();
    wr(3, 3, 20'h00301, 16'h7777, 2'b00, 2, 14, 0, 2'b00, 4);
    check("R2 tie prefers enable", 32'(err), 32'h01);
    check("R2 tie src", 32'({vo, vc}), 32'b0000);
  endtask

  task automatic t_asu();
    clear_all();
    wr(1, 1, 20'h00400, 16'h4444, 2'b00, 1, 13, 0, 2'b00, 6);
    check("R4 addr setup 14", 32'(err), 32'h02);
    check("R4 src", 32'({vo, vc}), 32'b0101);
    clear_all();
    wr(1, 1, 20'h00401, 16'h4444, 2'b00, 2, 13, 0, 2'b00, 6);
    exp_cnt++;
    check("R4 addr setup 15", 32'(err), 0);
    check("R4 cnt", 32'(cnt), 32'(exp_cnt));
  endtask

  task automatic t_ahold();
    clear_all();
    addr = 20'h00500; data = 16'h5555; host = 1'b1;
    ce_n = 1'b1; we_n = 1'b0; be_n = 2'b00;
    step(2);
    ce_n = 1'b0;
    step(16);
    addr = 20'h00501;
    step(4);
    ce_n = 1'b1;
    step(1);
    check("R5 hold err", 32'(err), 32'h06);
    check("R5 done", 32'(done), 1);
    check("R5 cnt unchanged", 32'(cnt), 32'(exp_cnt));
    go_idle();
  endtask

  task automatic t_dsu();
    clear_all();
    wr(1, 1, 20'h00600, 16'hC3C3, 2'b00, 2, 15, 8, 2'b01, 4);
    check("R6 data setup 7", 32'(err), 32'h08);
    clear_all();
    wr(1, 1, 20'h00601, 16'hC3C3, 2'b00, 2, 15, 7, 2'b01, 4);
    exp_cnt++;
    check("R6 data setup 8", 32'(err), 0);
    clear_all();
    wr(1, 1, 20'h00602, 16'h3CC3, 2'b10, 2, 15, 14, 2'b10, 4);
    exp_cnt++;
    check("R6 disabled lane ignored", 32'(err), 0);
    check("R6 cnt", 32'(cnt), 32'(exp_cnt));
  endtask

  task automatic t_cycle();
    clear_all();
    addr = 20'h00700;
    step(5);
    addr = 20'h00701;
    step(1);
    check("R7 short cycle", 32'(err), 32'h10);
    step(20);
    addr = 20'h00702;
    step(2);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    step(15);
    addr = 20'h00703;
    step(1);
    check("R7 cycle 18 ok", 32'(err), 0);
  endtask

  task automatic t_cont();
    clear_all();
    ce_n = 1'b0; be_n = 2'b00; oe_n = 1'b0; we_n = 1'b1; host = 1'b1;
    step(1);
    check("R8 read contention", 32'(err), 32'h20);
    go_idle();
    clear_all();
    ce_n = 1'b0; be_n = 2'b00; oe_n = 1'b0; we_n = 1'b0; host = 1'b0;
    step(4);
    host = 1'b1;
    step(1);
    check("R8 drive on 5th low sample", 32'(err), 32'h20);
    go_idle();
    clear_all();
    addr = 20'h00800; data = 16'h8181;
    ce_n = 1'b0; be_n = 2'b00; oe_n = 1'b0; we_n = 1'b0; host = 1'b0;
    step(5);
    host = 1'b1;
    step(10);
    we_n = 1'b1; host = 1'b0;
    step(1);
    exp_cnt++;
    check("R8 drive from 6th sample ok", 32'(err), 0);
    check("R8 cnt", 32'(cnt), 32'(exp_cnt));
    go_idle();
  endtask

  task automatic t_sticky();
    clear_all();
    addr = 20'h00900;
    step(3);
    addr = 20'h00901;
    step(30);
    check("R9 sticky", 32'(err), 32'h10);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    check("R9 cleared", 32'(err), 0);
    check("R9 final cnt", 32'(cnt), 32'(exp_cnt));
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_basic();
    t_width();
    t_src();
    t_asu();
    t_ahold();
    t_dsu();
    t_cycle();
    t_cont();
    t_sticky();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule